// File: doc/BRIEF.md
# Write-Only Serial Control Slave for Backlight and Regulator Settings

This block is a receive-only I2C target that turns three-byte write transfers into the control settings of a four-channel LED backlight driver and two linear regulators. It oversamples SCL and SDA on the system clock, passes both lines through a two-flop synchroniser and a three-sample glitch filter, finds START and STOP conditions, matches its fixed 7-bit bus address and pulls SDA low for the acknowledge slot of each accepted byte.

The first byte carries the address and a write direction bit. The second byte chooses a function: either one regulator (with its on/off flag) or the LED group (with one enable bit per channel). The third byte carries a 5-bit step code: a regulator voltage code or the shared LED current code. A setting changes only after the whole data byte has been acknowledged. Two conditions wipe every setting back to zero: a low level on the chip enable, and both bus lines held low for longer than a parameterised shutdown time, counted on the system clock.

Top module: `bl_cfg_slave`

## Requirements
- R1: The first byte is acknowledged only when it equals 0xA8: address 1010100 in bits 7..1 with bit 0 (direction) at 0. Any other value gets no acknowledge, and the block ignores the bus until the next START.
- R2: The second byte is acknowledged when bits 7..5 are 001 and bits 3..1 are 000 or 001 (regulator 1 or 2), or when bits 7..5 are 010 (LED group). Bit 4 is ignored. Any other second byte gets no acknowledge, and the transfer is dropped.
- R3: After the data byte is acknowledged, the selected regulator takes bit 0 of the second byte as its enable (`ldo_en[k]`) and bits 4..0 of the third byte as its code (`ldo_code[5k+4:5k]`). Bits 7..5 of the third byte have no effect. The data byte is always acknowledged when the first two bytes were.
- R4: A STOP or a repeated START before the data byte has been acknowledged leaves every setting unchanged.
- R5: An LED group write copies bits 3..0 of the second byte to `led_en[3:0]` (bit 0 is channel 1, and 1 means on) and bits 4..0 of the third byte to `led_code`.
- R6: A pulse on SCL or SDA that lasts fewer than three system clocks is ignored. A transfer that carries such pulses lands exactly as a clean one would.
- R7: When SCL and SDA are both low for `CLK_KHZ*SHDN_US/1000` system clocks, `shutdown` rises and every setting clears to zero. Shorter low periods change nothing. The next START clears `shutdown`.
- R8: While `chip_en` is low, every setting is zero, `shutdown` is low, SDA is released, and no byte is acknowledged.
- R9: After reset, every setting is zero and both `sda_oe` and `shutdown` are low.
- R10: `sda_oe` changes only while the filtered SCL is low. SDA is released again within the low phase that follows the acknowledge clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling and timing |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_en | input | 1 | Chip enable; low clears all state |
| scl_in | input | 1 | Bus clock line as sampled at the pad |
| sda_in | input | 1 | Bus data line as sampled at the pad |
| sda_oe | output | 1 | High pulls the data line low (acknowledge) |
| ldo_en | output | 2 | Regulator on/off flags, bit k for regulator k+1 |
| ldo_code | output | 10 | Regulator voltage codes, 5 bits per regulator |
| led_en | output | 4 | LED channel enables, bit 0 is channel 1 |
| led_code | output | 5 | Shared LED current step code |
| shutdown | output | 1 | High after a long low hold of both bus lines |

## Verification
A wrong protocol state shows up first on `sda_oe`. A misplaced bit count or a bad decode moves or drops an acknowledge within the same byte, so the host sees the error on the ninth clock of that byte. A wrong decode or a lost commit shows on the setting outputs a few system clocks after the data byte's acknowledge clock falls, and at the latest by the STOP that follows. A wrong shutdown counter shows as `shutdown` rising on a hold that is too short, or staying low on a hold that is long enough. For that reason, holds just under and just over the threshold are both applied.

// File: rtl/bl_cfg_pkg.sv
package bl_cfg_pkg;
  localparam int CODE_W  = 5;
  localparam int NUM_LDO = 2;
  localparam int NUM_LED = 4;

  localparam logic [6:0] DEV_ADDR = 7'h54;
  localparam logic [2:0] FN_LDO   = 3'b001;
  localparam logic [2:0] FN_LED   = 3'b010;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RX   = 2'd1,
    PH_ACK  = 2'd2
  } phase_t;
endpackage

// File: rtl/bl_bus_filt.sv
module bl_bus_filt (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [1:0] sync_q;
  logic [2:0] hist_q;
  logic       agree;

  assign agree = (hist_q == 3'b111) || (hist_q == 3'b000);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      hist_q <= 3'b111;
      dout   <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], din};
      hist_q <= {hist_q[1:0], sync_q[1]};
      if (agree) dout <= hist_q[0];
    end
  end
endmodule

// File: rtl/bl_hold_timer.sv
module bl_hold_timer #(
  parameter int CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chip_en,
  input  logic scl_f,
  input  logic sda_f,
  input  logic start_det,
  output logic hit,
  output logic shutdown
);
  localparam int W = $clog2(CYC + 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         hit_d, shdn_d;
  logic         both_low;

  assign both_low = chip_en && !scl_f && !sda_f;

  always_comb begin
    cnt_d = cnt_q;
    if (!both_low)                    cnt_d = '0;
    else if (cnt_q != W'(CYC))        cnt_d = cnt_q + 1'b1;
    hit_d = both_low && (cnt_q == W'(CYC - 1));
    shdn_d = shutdown;
    if (!chip_en)      shdn_d = 1'b0;
    else if (hit)      shdn_d = 1'b1;
    else if (start_det) shdn_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      hit      <= 1'b0;
      shutdown <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      hit      <= hit_d;
      shutdown <= shdn_d;
    end
  end
endmodule

// File: rtl/bl_i2c_wr.sv
module bl_i2c_wr
  import bl_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       chip_en,
  input  logic       abort,
  input  logic       scl_f,
  input  logic       sda_f,
  output logic       start_det,
  output logic       sda_oe,
  output logic       commit,
  output logic [7:0] sub_q,
  output logic [7:0] data_q
);
  phase_t     ph_q, ph_d;
  logic [1:0] idx_q, idx_d;
  logic [3:0] bit_q, bit_d;
  logic [7:0] sh_q, sh_d, sub_d, data_d;
  logic       scl_p, sda_p, oe_d, commit_d;
  logic       stop_det, rise, fall, ack_ok, sub_ok;

  assign start_det = scl_f && scl_p && sda_p && !sda_f;
  assign stop_det  = scl_f && scl_p && !sda_p && sda_f;
  assign rise      = scl_f && !scl_p;
  assign fall      = !scl_f && scl_p;

  assign sub_ok = (sh_q[7:5] == FN_LED) ||
                  ((sh_q[7:5] == FN_LDO) && (int'(sh_q[3:1]) < NUM_LDO));

  always_comb begin
    case (idx_q)
      2'd0:    ack_ok = (sh_q == {DEV_ADDR, 1'b0});
      2'd1:    ack_ok = sub_ok;
      default: ack_ok = 1'b1;
    endcase
  end

  always_comb begin
    ph_d = ph_q; idx_d = idx_q; bit_d = bit_q; sh_d = sh_q;
    sub_d = sub_q; data_d = data_q; oe_d = sda_oe; commit_d = 1'b0;
    if (!chip_en || abort) begin
      ph_d = PH_IDLE; oe_d = 1'b0;
    end else if (start_det) begin
      ph_d = PH_RX; idx_d = 2'd0; bit_d = 4'd0; oe_d = 1'b0;
    end else if (stop_det) begin
      ph_d = PH_IDLE; oe_d = 1'b0;
    end else begin
      case (ph_q)
        PH_RX: begin
          if (rise && bit_q != 4'd8) begin
            sh_d  = {sh_q[6:0], sda_f};
            bit_d = bit_q + 4'd1;
          end else if (fall && bit_q == 4'd8) begin
            if (ack_ok) begin
              ph_d = PH_ACK; oe_d = 1'b1;
              if (idx_q == 2'd1) sub_d  = sh_q;
              if (idx_q == 2'd2) data_d = sh_q;
            end else begin
              ph_d = PH_IDLE;
            end
          end
        end
        PH_ACK: begin
          if (fall) begin
            oe_d = 1'b0;
            if (idx_q == 2'd2) begin
              commit_d = 1'b1; ph_d = PH_IDLE;
            end else begin
              idx_d = idx_q + 2'd1; bit_d = 4'd0; ph_d = PH_RX;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE; idx_q <= '0; bit_q <= '0; sh_q <= '0;
      sub_q <= '0; data_q <= '0; sda_oe <= 1'b0; commit <= 1'b0;
      scl_p <= 1'b1; sda_p <= 1'b1;
    end else begin
      ph_q <= ph_d; idx_q <= idx_d; bit_q <= bit_d; sh_q <= sh_d;
      sub_q <= sub_d; data_q <= data_d; sda_oe <= oe_d; commit <= commit_d;
      scl_p <= scl_f; sda_p <= sda_f;
    end
  end
endmodule

// File: rtl/bl_cfg_bank.sv
module bl_cfg_bank
  import bl_cfg_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clear,
  input  logic                      commit,
  input  logic [7:0]                sub,
  input  logic [7:0]                data,
  output logic [NUM_LDO-1:0]        ldo_en,
  output logic [NUM_LDO*CODE_W-1:0] ldo_code,
  output logic [NUM_LED-1:0]        led_en,
  output logic [CODE_W-1:0]         led_code
);
  for (genvar k = 0; k < NUM_LDO; k++) begin : g_ldo
    logic              en_q;
    logic [CODE_W-1:0] code_q;
    logic              wr;
    assign wr = commit && (sub[7:5] == FN_LDO) && (sub[3:1] == 3'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q <= 1'b0; code_q <= '0;
      end else if (clear) begin
        en_q <= 1'b0; code_q <= '0;
      end else if (wr) begin
        en_q <= sub[0]; code_q <= data[CODE_W-1:0];
      end
    end
    assign ldo_en[k] = en_q;
    assign ldo_code[k*CODE_W +: CODE_W] = code_q;
  end

  logic led_wr;
  assign led_wr = commit && (sub[7:5] == FN_LED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      led_en <= '0; led_code <= '0;
    end else if (clear) begin
      led_en <= '0; led_code <= '0;
    end else if (led_wr) begin
      led_en <= sub[NUM_LED-1:0]; led_code <= data[CODE_W-1:0];
    end
  end
endmodule

// File: rtl/bl_cfg_slave.sv
module bl_cfg_slave
  import bl_cfg_pkg::*;
#(
  parameter int CLK_KHZ = 125000,
  parameter int SHDN_US = 1000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      chip_en,
  input  logic                      scl_in,
  input  logic                      sda_in,
  output logic                      sda_oe,
  output logic [NUM_LDO-1:0]        ldo_en,
  output logic [NUM_LDO*CODE_W-1:0] ldo_code,
  output logic [NUM_LED-1:0]        led_en,
  output logic [CODE_W-1:0]         led_code,
  output logic                      shutdown
);
  localparam int SHDN_CYC = CLK_KHZ * SHDN_US / 1000;

  logic [1:0] raw, filt;
  logic       scl_f, sda_f, start_det, shdn_hit, commit;
  logic [7:0] sub_q, data_q;

  assign raw = {scl_in, sda_in};
  for (genvar i = 0; i < 2; i++) begin : g_line
    bl_bus_filt u_filt (.clk(clk), .rst_n(rst_n), .din(raw[i]), .dout(filt[i]));
  end
  assign scl_f = filt[1];
  assign sda_f = filt[0];

  bl_hold_timer #(.CYC(SHDN_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .scl_f(scl_f), .sda_f(sda_f),
    .start_det(start_det), .hit(shdn_hit), .shutdown(shutdown)
  );

  bl_i2c_wr u_proto (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .abort(shdn_hit),
    .scl_f(scl_f), .sda_f(sda_f), .start_det(start_det), .sda_oe(sda_oe),
    .commit(commit), .sub_q(sub_q), .data_q(data_q)
  );

  bl_cfg_bank u_bank (
    .clk(clk), .rst_n(rst_n), .clear(!chip_en || shdn_hit), .commit(commit),
    .sub(sub_q), .data(data_q), .ldo_en(ldo_en), .ldo_code(ldo_code),
    .led_en(led_en), .led_code(led_code)
  );
endmodule

// File: rtl/bl_cfg_checker.sv
module bl_cfg_checker #(
  parameter int NL = 2,
  parameter int CW = 5,
  parameter int NE = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            chip_en,
  input logic            scl_f,
  input logic            commit,
  input logic            shdn_hit,
  input logic            sda_oe,
  input logic            shutdown,
  input logic [NL-1:0]   ldo_en,
  input logic [NL*CW-1:0] ldo_code,
  input logic [NE-1:0]   led_en,
  input logic [CW-1:0]   led_code
);
  logic all_zero;
  assign all_zero = (ldo_en == '0) && (ldo_code == '0) && (led_en == '0) && (led_code == '0);

  // R3 / R4: settings move only on a completed write or a clear
  p_hold_without_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit && chip_en && !shdn_hit) |=> $stable({ldo_en, ldo_code, led_en, led_code}));

  // R3: the commit strobe falls in the SCL low phase after the data acknowledge
  p_commit_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !scl_f);

  // R7: shutdown comes with cleared settings
  p_shutdown_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shutdown) |-> all_zero);

  // R8: chip enable low wipes everything
  p_enable_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en |=> (all_zero && !shutdown && !sda_oe));

  // R10: the data line driver toggles only with SCL low
  p_oe_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n || !chip_en)
    (sda_oe != $past(sda_oe)) |-> !scl_f);
endmodule

bind bl_cfg_slave bl_cfg_checker #(
  .NL(bl_cfg_pkg::NUM_LDO), .CW(bl_cfg_pkg::CODE_W), .NE(bl_cfg_pkg::NUM_LED)
) u_chk (
  .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .scl_f(scl_f), .commit(commit),
  .shdn_hit(shdn_hit), .sda_oe(sda_oe), .shutdown(shutdown), .ldo_en(ldo_en),
  .ldo_code(ldo_code), .led_en(led_en), .led_code(led_code)
);

// File: tb/tb_bl_cfg_slave.sv
module tb_bl_cfg_slave;
  localparam int Q        = 12;
  localparam int CLK_KHZ  = 125000;
  localparam int SHDN_US  = 2;
  localparam int SHDN_CYC = CLK_KHZ * SHDN_US / 1000;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, chip_en, scl_h, sda_h;
  logic       sda_line;
  logic       sda_oe, shutdown;
  logic [1:0] ldo_en;
  logic [9:0] ldo_code;
  logic [3:0] led_en;
  logic [4:0] led_code;

  assign sda_line = sda_h & ~sda_oe;

  bl_cfg_slave #(.CLK_KHZ(CLK_KHZ), .SHDN_US(SHDN_US)) dut (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .scl_in(scl_h), .sda_in(sda_line),
    .sda_oe(sda_oe), .ldo_en(ldo_en), .ldo_code(ldo_code), .led_en(led_en),
    .led_code(led_code), .shutdown(shutdown)
  );

  logic [1:0] m_ldo_en;
  logic [9:0] m_ldo_code;
  logic [3:0] m_led_en;
  logic [4:0] m_led_code;
  logic       m_shdn;
  int         checks = 0;
  int         errors = 0;
  bit         done = 0;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_regs(input string req);
    chk(req, "ldo_en",   32'(ldo_en),   32'(m_ldo_en));
    chk(req, "ldo_code", 32'(ldo_code), 32'(m_ldo_code));
    chk(req, "led_en",   32'(led_en),   32'(m_led_en));
    chk(req, "led_code", 32'(led_code), 32'(m_led_code));
    chk(req, "shutdown", 32'(shutdown), 32'(m_shdn));
  endtask

  function automatic bit sub_legal(input logic [7:0] s);
    return (s[7:5] == 3'b010) || (s[7:5] == 3'b001 && s[3:1] <= 3'd1);
  endfunction

  function automatic void model_clear();
    m_ldo_en = '0; m_ldo_code = '0; m_led_en = '0; m_led_code = '0;
  endfunction

  function automatic void model_apply(input logic [7:0] s, input logic [7:0] d);
    if (s[7:5] == 3'b010) begin
      m_led_en = s[3:0]; m_led_code = d[4:0];
    end else if (s[3:1] == 3'd0) begin
      m_ldo_en[0] = s[0]; m_ldo_code[4:0] = d[4:0];
    end else begin
      m_ldo_en[1] = s[0]; m_ldo_code[9:5] = d[4:0];
    end
  endfunction

  task automatic bus_start();
    sda_h = 1'b1; tick(Q); scl_h = 1'b1; tick(Q);
    sda_h = 1'b0; tick(Q); scl_h = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; tick(Q); scl_h = 1'b1; tick(Q); sda_h = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_h = b[i]; tick(Q);
      scl_h = 1'b1;
      if (glitch) begin
        tick(Q - 2); scl_h = 1'b0; tick(2); scl_h = 1'b1; tick(4);
        sda_h = ~b[i]; tick(2); sda_h = b[i]; tick(Q - 6);
      end else begin
        tick(2 * Q);
      end
      scl_h = 1'b0; tick(Q);
    end
    sda_h = 1'b1; tick(Q); scl_h = 1'b1; tick(Q);
    ack = !sda_line; tick(Q); scl_h = 1'b0; tick(Q);
    // R10: released within the low phase after the acknowledge clock
    chk("R10", "sda released after ack clock", 32'(sda_oe), 32'd0);
  endtask

  // mode 0: full write, 1: STOP after sub byte, 2: repeated START after sub byte
  task automatic write3(input logic [7:0] a, input logic [7:0] s, input logic [7:0] d,
                        input int mode, input bit glitch, input string req);
    bit k0, k1, k2, e0, e1;
    e0 = chip_en && (a == 8'hA8);
    e1 = e0 && sub_legal(s);
    bus_start();
    if (chip_en) m_shdn = 1'b0;
    send_byte(a, glitch, k0); chk(req, "address ack", 32'(k0), 32'(e0));
    send_byte(s, glitch, k1); chk(req, "sub ack", 32'(k1), 32'(e1));
    if (mode == 1) begin
      bus_stop();
    end else if (mode == 2) begin
      bus_start(); bus_stop();
    end else begin
      send_byte(d, glitch, k2); chk(req, "data ack", 32'(k2), 32'(e1));
      bus_stop();
      if (e1) model_apply(s, d);
    end
    tick(10);
    chk_regs(req);
  endtask

  task automatic hold_low(input int n);
    sda_h = 1'b0; tick(Q); scl_h = 1'b0; tick(n);
    scl_h = 1'b1; tick(Q); sda_h = 1'b1; tick(Q); tick(10);
  endtask

  function automatic string fmt_req(input logic [7:0] a, input logic [7:0] s);
    if (a != 8'hA8) return "R1";
    if (!sub_legal(s)) return "R2";
    if (s[7:5] == 3'b010) return "R5";
    return "R3";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int r;
    r = $urandom(32'd4242);
    rst_n = 1'b0; chip_en = 1'b1; scl_h = 1'b1; sda_h = 1'b1;
    model_clear(); m_shdn = 1'b0;
    tick(5); rst_n = 1'b1; tick(5);

    // R9: reset values
    chk_regs("R9");
    chk("R9", "sda_oe after reset", 32'(sda_oe), 32'd0);

    // R3 regulator 1, regulator 2 with upper data bits set
    write3(8'hA8, 8'b001_0_000_1, 8'h13, 0, 0, "R3");
    write3(8'hA8, 8'b001_1_001_1, 8'hFA, 0, 0, "R3");
    // R5 LED group
    write3(8'hA8, 8'b010_0_1010, 8'h1F, 0, 0, "R5");
    // R2 unknown function and bad selector
    write3(8'hA8, 8'b011_0_0001, 8'h05, 0, 0, "R2");
    write3(8'hA8, 8'b001_0_010_1, 8'h05, 0, 0, "R2");
    // R1 wrong address and read direction
    write3(8'hAA, 8'b010_0_1111, 8'h01, 0, 0, "R1");
    write3(8'hA9, 8'b010_0_1111, 8'h01, 0, 0, "R1");
    // R4 aborted transfers
    write3(8'hA8, 8'b010_0_0101, 8'h02, 1, 0, "R4");
    write3(8'hA8, 8'b001_0_000_0, 8'h02, 2, 0, "R4");
    // R6 glitches on both lines
    write3(8'hA8, 8'b010_0_0110, 8'h0B, 0, 1, "R6");
    write3(8'hA8, 8'b001_0_001_0, 8'h07, 0, 1, "R6");

    // random mix
    for (int n = 0; n < 30; n++) begin
      logic [7:0] a, s, d;
      int mode, sel;
      a = ($urandom % 4 == 0) ? 8'($urandom) : 8'hA8;
      sel = $urandom % 3;
      s = 8'($urandom);
      if (sel == 0) s[7:5] = 3'b001;
      else if (sel == 1) s[7:5] = 3'b010;
      d = 8'($urandom);
      mode = $urandom % 6;
      if (mode > 2) mode = 0;
      write3(a, s, d, mode, 0, (mode != 0) ? "R4" : fmt_req(a, s));
    end

    // R7 below and above the shutdown interval
    write3(8'hA8, 8'b010_0_1111, 8'h11, 0, 0, "R5");
    hold_low(SHDN_CYC - 60);
    m_shdn = 1'b0;
    chk_regs("R7");
    hold_low(SHDN_CYC + 60);
    model_clear(); m_shdn = 1'b1;
    chk_regs("R7");
    write3(8'hA8, 8'b001_0_000_1, 8'h09, 0, 0, "R7");

    // R8 chip enable low
    write3(8'hA8, 8'b010_0_0011, 8'h0C, 0, 0, "R5");
    chip_en = 1'b0; tick(5);
    model_clear(); m_shdn = 1'b0;
    chk_regs("R8");
    write3(8'hA8, 8'b010_0_1111, 8'h1E, 0, 0, "R8");
    chk("R8", "sda_oe with enable low", 32'(sda_oe), 32'd0);
    chip_en = 1'b1; tick(10);
    write3(8'hA8, 8'b001_0_001_1, 8'h15, 0, 0, "R8");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule